// File: doc/BRIEF.md
# Host-Bus I/O Expander Decoder

This block sits on a 16-bit parallel host bus and splits the address space into a few windows. The top four address bits select the window, and the lower bits are ignored. One window passes bytes to and from an external USB FIFO bridge and pulses that bridge's read and write strobes. Another window returns a snapshot of the bridge's active-low handshake flags. The remaining windows hold a pin-function select register and a general output register, and one window fires a watchdog service pulse on any write.

The host issues single-cycle read and write strobes that are synchronous to `clk_i`. Every output of the block is registered, so each result appears one cycle after the strobe that caused it. Read data stays on `bus_rdata_o` until the next read.

Top module: `io_exp_decoder`

## Requirements
- R1: While `rst_ni` is low and after its release, `bus_rdata_o` is 0, `usb_rd_o`, `usb_wr_o` and `wd_kick_o` are 0, `pin_sel_o` is 0 and `dout_o` is all ones, so every reset line is inactive high.
- R2: A write with address[15:12] = 4'h8 drives `usb_wdata_o` with data bits 7:0 and raises `usb_wr_o` for exactly one cycle, starting on the edge that samples the strobe.
- R3: A read with address[15:12] = 4'h8 raises `usb_rd_o` for exactly one cycle and loads `bus_rdata_o` with {8'h00, `usb_data_i`}, with `usb_data_i` sampled on the same edge.
- R4: A read with address[15:12] = 4'h9 loads `bus_rdata_o` with bit 14 = `usb_pwr_ni` (0 means enumerated), bit 13 = `usb_txe_ni` (0 means the transmit FIFO has room), bit 12 = `usb_rxf_ni` (0 means the receive FIFO holds a byte), and all other bits 0.
- R5: A write with address[15:12] = 4'hA loads `pin_sel_o` from data bits 7:0. Bit n = 1 gives shared pin n its slave-select role, and bit n = 0 leaves it as general I/O.
- R6: A write with address[15:12] = 4'hC loads all 16 data bits into `dout_o`. Bit 15 is an active-low reset output, so writing 0 to it drives that line low.
- R7: Any write with address[15:12] = 4'hE raises `wd_kick_o` for exactly one cycle whatever the data, and changes neither `pin_sel_o` nor `dout_o`.
- R8: A read with address[15:12] equal to 4'hA, 4'hC, 4'hE or any unmapped value loads `bus_rdata_o` with 0 and raises no USB strobe.
- R9: Address bits 11:0 have no effect on decoding.
- R10: Writes to 4'h9 or to an unmapped region change no output and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rd_i | input | 1 | Single-cycle host read strobe |
| bus_wr_i | input | 1 | Single-cycle host write strobe |
| bus_addr_i | input | 16 | Host address |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Registered read data |
| usb_data_i | input | 8 | Byte returned by the USB bridge |
| usb_wdata_o | output | 8 | Byte sent to the USB bridge |
| usb_rd_o | output | 1 | One-cycle read strobe to the bridge |
| usb_wr_o | output | 1 | One-cycle write strobe to the bridge |
| usb_pwr_ni | input | 1 | Bridge enumerated flag, active low |
| usb_txe_ni | input | 1 | Transmit FIFO has room, active low |
| usb_rxf_ni | input | 1 | Receive FIFO holds data, active low |
| pin_sel_o | output | 8 | Per-pin slave-select / general I/O choice |
| dout_o | output | 16 | General output latch, bit 15 is an active-low reset |
| wd_kick_o | output | 1 | One-cycle watchdog service pulse |

## Verification
The assertions assume that the host never raises `bus_rd_i` and `bus_wr_i` in the same cycle, and that each strobe lasts one cycle and is followed by at least one idle cycle. Under those conditions the three output pulses are mutually exclusive and each falls after one cycle. The stimulus tasks honour this by raising a strobe for a single cycle and then dropping it for at least one cycle. The USB flag and data inputs change only while no read strobe is high.

// File: rtl/io_exp_pkg.sv
package io_exp_pkg;
  typedef enum logic [3:0] {
    RGN_USB_DATA = 4'h8,
    RGN_USB_STAT = 4'h9,
    RGN_PIN_SEL  = 4'hA,
    RGN_DOUT     = 4'hC,
    RGN_WD_KICK  = 4'hE
  } rgn_e;

  typedef struct packed {
    logic usb_data;
    logic usb_stat;
    logic pin_sel;
    logic dout;
    logic wd_kick;
  } sel_t;
endpackage

// File: rtl/io_exp_addr_dec.sv
module io_exp_addr_dec
  import io_exp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  output sel_t          sel_o
);
  localparam int RGN_LSB = AW - 4;

  logic [3:0] rgn;
  assign rgn = addr_i[AW-1:RGN_LSB];

  always_comb begin
    sel_o = '0;
    unique case (rgn)
      RGN_USB_DATA: sel_o.usb_data = 1'b1;
      RGN_USB_STAT: sel_o.usb_stat = 1'b1;
      RGN_PIN_SEL:  sel_o.pin_sel  = 1'b1;
      RGN_DOUT:     sel_o.dout     = 1'b1;
      RGN_WD_KICK:  sel_o.wd_kick  = 1'b1;
      default:      sel_o = '0;
    endcase
  end

  // R9
  always_comb sel_onehot_chk: assert ($onehot0(sel_o));
endmodule

// File: rtl/io_exp_wr_regs.sv
module io_exp_wr_regs
  import io_exp_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          USB_W    = 8,
  parameter int          SEL_W    = 8,
  parameter logic [DW-1:0] DOUT_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  sel_t             sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [USB_W-1:0] usb_wdata_o,
  output logic             usb_wr_o,
  output logic [SEL_W-1:0] pin_sel_o,
  output logic [DW-1:0]    dout_o,
  output logic             wd_kick_o
);
  logic wr_usb, wr_sel, wr_dout, wr_kick;
  assign wr_usb  = wr_i & sel_i.usb_data;
  assign wr_sel  = wr_i & sel_i.pin_sel;
  assign wr_dout = wr_i & sel_i.dout;
  assign wr_kick = wr_i & sel_i.wd_kick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usb_wdata_o <= '0;
      usb_wr_o    <= 1'b0;
    end else begin
      usb_wr_o <= wr_usb;
      if (wr_usb) usb_wdata_o <= wdata_i[USB_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pin_sel_o <= '0;
    else if (wr_sel) pin_sel_o <= wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dout_o <= DOUT_RST;
    else if (wr_dout) dout_o <= wdata_i;
  end

  // data bits deliberately unused for the kick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_kick_o <= 1'b0;
    else         wd_kick_o <= wr_kick;
  end

  // R2
  usb_wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_wr_o |=> !usb_wr_o);
  // R2
  usb_wr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_wr_o |-> $past(wr_i));
  // R7
  wd_kick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_kick_o |=> !wd_kick_o);
  // R7
  kick_keeps_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_kick_o |-> $stable(dout_o) && $stable(pin_sel_o));
  // R10
  dout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(dout_o) && $stable(pin_sel_o));
endmodule

// File: rtl/io_exp_rd_path.sv
module io_exp_rd_path
  import io_exp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int USB_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  sel_t             sel_i,
  input  logic [USB_W-1:0] usb_data_i,
  input  logic [2:0]       stat_ni,
  output logic [DW-1:0]    rdata_o,
  output logic             usb_rd_o
);
  localparam int STAT_LSB = DW - 4;

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sel_i.usb_data)      rd_mux[USB_W-1:0] = usb_data_i;
    else if (sel_i.usb_stat) rd_mux[STAT_LSB +: 3] = stat_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      usb_rd_o <= 1'b0;
    end else begin
      usb_rd_o <= rd_i & sel_i.usb_data;
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  // R3
  usb_rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rd_o |=> !usb_rd_o);
  // R3
  usb_rd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rd_o |-> $past(rd_i));
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
  // R4
  stat_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[DW-1]);
endmodule

// File: rtl/io_exp_decoder.sv
module io_exp_decoder
  import io_exp_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 16,
  parameter int            USB_W    = 8,
  parameter int            SEL_W    = 8,
  parameter logic [DW-1:0] DOUT_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [USB_W-1:0] usb_data_i,
  output logic [USB_W-1:0] usb_wdata_o,
  output logic             usb_rd_o,
  output logic             usb_wr_o,
  input  logic             usb_pwr_ni,
  input  logic             usb_txe_ni,
  input  logic             usb_rxf_ni,
  output logic [SEL_W-1:0] pin_sel_o,
  output logic [DW-1:0]    dout_o,
  output logic             wd_kick_o
);
  sel_t sel;

  io_exp_addr_dec #(.AW(AW)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  io_exp_wr_regs #(
    .DW(DW), .USB_W(USB_W), .SEL_W(SEL_W), .DOUT_RST(DOUT_RST)
  ) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (bus_wr_i),
    .sel_i       (sel),
    .wdata_i     (bus_wdata_i),
    .usb_wdata_o (usb_wdata_o),
    .usb_wr_o    (usb_wr_o),
    .pin_sel_o   (pin_sel_o),
    .dout_o      (dout_o),
    .wd_kick_o   (wd_kick_o)
  );

  io_exp_rd_path #(.DW(DW), .USB_W(USB_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (bus_rd_i),
    .sel_i      (sel),
    .usb_data_i (usb_data_i),
    .stat_ni    ({usb_pwr_ni, usb_txe_ni, usb_rxf_ni}),
    .rdata_o    (bus_rdata_o),
    .usb_rd_o   (usb_rd_o)
  );

  // R2 R3 R7 (host never reads and writes together)
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({usb_rd_o, usb_wr_o, wd_kick_o}));
endmodule

// File: tb/io_exp_decoder_bench.sv
`timescale 1ns/1ps
module io_exp_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [15:0] bus_addr_i = '0, bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [7:0]  usb_data_i = '0, usb_wdata_o;
  logic        usb_rd_o, usb_wr_o;
  logic        usb_pwr_ni = 1'b1, usb_txe_ni = 1'b1, usb_rxf_ni = 1'b1;
  logic [7:0]  pin_sel_o;
  logic [15:0] dout_o;
  logic        wd_kick_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  exp_rd_q[$];

  always #2.5 clk_i = ~clk_i;

  io_exp_decoder u_io_exp_decoder (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one-cycle write strobe, returns at the negedge after the edge
  task automatic do_wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic do_rd(logic [15:0] a, logic [15:0] exp, logic exp_usb_rd);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    exp_q.push_back(exp);
    exp_rd_q.push_back({7'd0, exp_usb_rd});
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    @(negedge clk_i);
    chk("R3 usb_rd one cycle", {15'd0, usb_rd_o}, 16'd0);
  endtask

  // monitor: pops expected read results after the sampling edge
  initial forever begin
    @(posedge clk_i);
    #1;
    if (bus_rd_i && exp_q.size() > 0) begin
      logic [15:0] e;
      logic [7:0]  er;
      e  = exp_q.pop_front();
      er = exp_rd_q.pop_front();
      chk("R3/R4/R8 read data", bus_rdata_o, e);
      chk("R3/R8 usb_rd strobe", {15'd0, usb_rd_o}, {8'd0, er});
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", bus_rdata_o, 16'h0000);
    chk("R1 dout", dout_o, 16'hFFFF);
    chk("R1 pin_sel", {8'd0, pin_sel_o}, 16'h0000);
    chk("R1 strobes", {13'd0, usb_rd_o, usb_wr_o, wd_kick_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", dout_o, 16'hFFFF);

    // R2 USB write
    @(negedge clk_i);
    bus_addr_i = 16'h8000; bus_wdata_i = 16'hBEA5; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    chk("R2 usb_wr high", {15'd0, usb_wr_o}, 16'd1);
    chk("R2 usb_wdata", {8'd0, usb_wdata_o}, 16'h00A5);
    @(negedge clk_i);
    chk("R2 usb_wr one cycle", {15'd0, usb_wr_o}, 16'd0);

    // R3 R9 USB read with nonzero low address bits
    usb_data_i = 8'h3C;
    do_rd(16'h8123, 16'h003C, 1'b1);
    usb_data_i = 8'hF0;
    do_rd(16'h8FFF, 16'h00F0, 1'b1);

    // R4 status patterns
    usb_pwr_ni = 1'b0; usb_txe_ni = 1'b1; usb_rxf_ni = 1'b0;
    do_rd(16'h9000, 16'h2000, 1'b0);
    usb_pwr_ni = 1'b1; usb_txe_ni = 1'b0; usb_rxf_ni = 1'b1;
    do_rd(16'h9ABC, 16'h5000, 1'b0);

    // R5 select register
    do_wr(16'hA000, 16'h12C3);
    chk("R5 pin_sel", {8'd0, pin_sel_o}, 16'h00C3);

    // R6 output register, reset bit driven low
    do_wr(16'hC004, 16'h7FFE);
    chk("R6 dout", dout_o, 16'h7FFE);
    chk("R6 reset bit low", {15'd0, dout_o[15]}, 16'd0);

    // R7 watchdog kick, two data patterns
    do_wr(16'hE000, 16'h0000);
    chk("R7 kick high", {15'd0, wd_kick_o}, 16'd1);
    chk("R7 dout unchanged", dout_o, 16'h7FFE);
    @(negedge clk_i);
    chk("R7 kick one cycle", {15'd0, wd_kick_o}, 16'd0);
    do_wr(16'hE5A5, 16'hFFFF);
    chk("R7 kick any data", {15'd0, wd_kick_o}, 16'd1);
    chk("R7 sel unchanged", {8'd0, pin_sel_o}, 16'h00C3);

    // R8 write-only and unmapped reads return zero
    do_rd(16'hA000, 16'h0000, 1'b0);
    do_rd(16'hC000, 16'h0000, 1'b0);
    do_rd(16'hE000, 16'h0000, 1'b0);
    do_rd(16'h3000, 16'h0000, 1'b0);

    // R10 ignored writes
    do_wr(16'h9000, 16'h0000);
    chk("R10 status write dout", dout_o, 16'h7FFE);
    chk("R10 status write strobes", {13'd0, usb_rd_o, usb_wr_o, wd_kick_o}, 16'h0000);
    do_wr(16'h1000, 16'h0055);
    chk("R10 unmapped write sel", {8'd0, pin_sel_o}, 16'h00C3);
    chk("R10 unmapped write usb", {8'd0, usb_wdata_o}, 16'h00A5);

    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule